// File: doc/BRIEF.md
# Strap-Addressed I2C Target Controller

This block is the target (slave) side of a two-wire serial control bus, used by a host controller to write and read 8-bit bytes to and from a processing core. The host always drives the clock line and starts every transfer. The block never drives the clock and never drives the data line high. It either pulls data low through `sdaDriveLow` or leaves it released, and the pad and pull-up sit outside the block. Both clock and data are brought in through synchronizer chains clocked by the system clock. START, STOP and bit edges are found on those synchronized copies, which lets the same logic serve standard-rate (100 kbit/s) and fast-rate (400 kbit/s) buses.

The 7-bit target address has a fixed upper part, binary 00111, followed by two board-level strap pins. Bit 1 of the address comes from `addrStrap[1]` and bit 0 from `addrStrap[0]`. After a matching address, written bytes are handed to the core with a one-cycle strobe. For reads, the block takes bytes from the core and shifts them onto the bus. Once a transaction has begun, a repeated START does not open a new transaction. The block then waits for a STOP.

Top module: `i2c_strap_slave`

## Requirements
- R1: While reset is held and right after it is released, `sdaDriveLow`, `rxValid` and `txLoad` are all 0.
- R2: The first byte after a START holds the address in bits 7..1, MSB first, with the read flag in bit 0 (1 = read). The block acknowledges by pulling data low during the ninth clock only when bits 7..1 equal {00111, addrStrap[1], addrStrap[0]}.
- R3: On an address mismatch, the block leaves data released and produces no `rxValid` and no `txLoad` until a STOP. A transaction with a matching address that follows the STOP is served normally.
- R4: In a write, each byte is sampled MSB first on rising clock edges. The byte appears on `rxData` with `rxValid` high for exactly one cycle after its eighth bit, and the block acknowledges it during the ninth clock.
- R5: In a read, the block captures `txData` and pulses `txLoad` for one cycle at the falling clock edge that ends each acknowledge slot. It then sends that byte MSB first, releasing data for a 1 bit and pulling it low for a 0 bit.
- R6: In a read, data low from the host on the ninth clock asks for another byte. Data high (NACK) ends output: data stays released and `txLoad` stays low until a STOP.
- R7: A START seen while a transaction is open is not acted on. No address is acknowledged and no byte is strobed until a STOP.
- R8: The block changes `sdaDriveLow` only while the clock line is low.
- R9: Writes and reads behave the same at a 100 kbit/s and a 400 kbit/s bus clock with a 50 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrStrap | input | 2 | Strap pins forming address bits 1 and 0 |
| txData | input | 8 | Byte offered by the core for the next read |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |
| rxData | output | 8 | Last byte written by the host |
| rxValid | output | 1 | One-cycle strobe marking a new `rxData` byte |
| txLoad | output | 1 | One-cycle strobe: `txData` was just taken |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, a 7-bit address and two straps. It changes the bus clock quarter-period between 32 and 125 system cycles, so one build exercises both the fast and the standard bus rate. A sweep pairs all four strap settings with all four strap-dependent addresses, which covers every match and mismatch the comparator can see. Directed transfers cover a repeated START in the middle of a write, a byte clocked after a NACK, and data clocked after a mismatch. Random transfers with mixed direction and length complete the run.

// File: rtl/i2c_strap_pkg.sv
`timescale 1ns/1ps
package i2c_strap_pkg;

  // Bus events found on the synchronized lines
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEvt;
    logic stopEvt;
  } busEvt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic countBit;
    logic shiftOut;
    logic loadTx;
    logic emitRx;
  } dpCmd_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ACK_WAIT,
    S_ACK_DRIVE,
    S_WRITE,
    S_READ,
    S_MACK,
    S_RD_NEXT,
    S_HOLD
  } state_t;

endpackage

// File: rtl/i2c_strap_dp.sv
`timescale 1ns/1ps
module i2c_strap_dp
  import i2c_strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 7,
  parameter int STRAP_W = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HIGH = 'b00111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] addrStrap,
  input  dpCmd_t             cmd,
  input  logic [ADDR_W:0]    txData,
  output busEvt_t            evt,
  output logic               sclQ,
  output logic               sdaQ,
  output logic               cntLast,
  output logic               cntFull,
  output logic               addrHit,
  output logic               rwBit,
  output logic               nextOut,
  output logic               loadMsb,
  output logic [ADDR_W:0]    rxData,
  output logic               rxValid,
  output logic               txLoad
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic [BYTE_W-1:0] shreg, nextByte;
  logic [CNT_W-1:0] bitCnt;

  // Synchronizer chains, idle level high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe[0] <= sclIn;
      sdaPipe[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclPipe[i] <= sclPipe[i-1];
        sdaPipe[i] <= sdaPipe[i-1];
      end
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclQ = sclPipe[SYNC_STAGES-1];
  assign sdaQ = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    evt.sclRise  = sclQ & ~sclPrev;
    evt.sclFall  = ~sclQ & sclPrev;
    evt.startEvt = sclQ & sclPrev & sdaPrev & ~sdaQ;
    evt.stopEvt  = sclQ & sclPrev & ~sdaPrev & sdaQ;
  end

  assign nextByte = {shreg[BYTE_W-2:0], sdaQ};
  assign addrHit  = (nextByte[BYTE_W-1:1] == {ADDR_HIGH, addrStrap});
  assign rwBit    = nextByte[0];
  assign nextOut  = shreg[BYTE_W-2];
  assign loadMsb  = txData[BYTE_W-1];
  assign cntLast  = (bitCnt == CNT_W'(BYTE_W - 1));
  assign cntFull  = (bitCnt == CNT_W'(BYTE_W));
  assign rxData   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bitCnt  <= '0;
      rxValid <= 1'b0;
      txLoad  <= 1'b0;
    end else begin
      if (cmd.loadTx)        shreg <= txData;
      else if (cmd.shiftIn)  shreg <= nextByte;
      else if (cmd.shiftOut) shreg <= {shreg[BYTE_W-2:0], 1'b0};

      if (cmd.clrCnt)                        bitCnt <= '0;
      else if (cmd.shiftIn || cmd.countBit)  bitCnt <= bitCnt + 1'b1;

      rxValid <= cmd.emitRx;
      txLoad  <= cmd.loadTx;
    end
  end
endmodule

// File: rtl/i2c_strap_ctrl.sv
`timescale 1ns/1ps
module i2c_strap_ctrl
  import i2c_strap_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  busEvt_t evt,
  input  logic    sdaQ,
  input  logic    cntLast,
  input  logic    cntFull,
  input  logic    addrHit,
  input  logic    rwBit,
  input  logic    nextOut,
  input  logic    loadMsb,
  output dpCmd_t  cmd,
  output logic    sdaDriveLow
);
  state_t state, nState;
  logic isRead, nIsRead, nDrive;

  always_comb begin
    nState  = state;
    nIsRead = isRead;
    nDrive  = sdaDriveLow;
    cmd     = '0;
    if (evt.stopEvt) begin
      nState = S_IDLE;
      nDrive = 1'b0;
    end else if (evt.startEvt) begin
      if (state == S_IDLE) begin
        nState     = S_ADDR;
        cmd.clrCnt = 1'b1;
      end else begin
        nState = S_HOLD;   // repeated START: wait for STOP
        nDrive = 1'b0;
      end
    end else begin
      unique case (state)
        S_ADDR: if (evt.sclRise) begin
          cmd.shiftIn = 1'b1;
          if (cntLast) begin
            if (addrHit) begin
              nIsRead = rwBit;
              nState  = S_ACK_WAIT;
            end else begin
              nState = S_HOLD;
            end
          end
        end
        S_ACK_WAIT: if (evt.sclFall) begin
          nDrive = 1'b1;
          nState = S_ACK_DRIVE;
        end
        S_ACK_DRIVE: if (evt.sclFall) begin
          cmd.clrCnt = 1'b1;
          if (isRead) begin
            cmd.loadTx = 1'b1;
            nDrive     = ~loadMsb;
            nState     = S_READ;
          end else begin
            nDrive = 1'b0;
            nState = S_WRITE;
          end
        end
        S_WRITE: if (evt.sclRise) begin
          cmd.shiftIn = 1'b1;
          if (cntLast) begin
            cmd.emitRx = 1'b1;
            nState     = S_ACK_WAIT;
          end
        end
        S_READ: begin
          if (evt.sclRise) cmd.countBit = 1'b1;
          if (evt.sclFall) begin
            if (cntFull) begin
              nDrive = 1'b0;
              nState = S_MACK;
            end else begin
              cmd.shiftOut = 1'b1;
              nDrive       = ~nextOut;
            end
          end
        end
        S_MACK: if (evt.sclRise) begin
          nState = sdaQ ? S_HOLD : S_RD_NEXT;
        end
        S_RD_NEXT: if (evt.sclFall) begin
          cmd.clrCnt = 1'b1;
          cmd.loadTx = 1'b1;
          nDrive     = ~loadMsb;
          nState     = S_READ;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      isRead      <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else begin
      state       <= nState;
      isRead      <= nIsRead;
      sdaDriveLow <= nDrive;
    end
  end
endmodule

// File: rtl/i2c_strap_slave.sv
`timescale 1ns/1ps
module i2c_strap_slave
  import i2c_strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 7,
  parameter int STRAP_W = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HIGH = 'b00111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] addrStrap,
  input  logic [ADDR_W:0]    txData,
  output logic               sdaDriveLow,
  output logic [ADDR_W:0]    rxData,
  output logic               rxValid,
  output logic               txLoad
);
  busEvt_t evt;
  dpCmd_t  cmd;
  logic sclQ, sdaQ, cntLast, cntFull, addrHit, rwBit, nextOut, loadMsb;
  logic startEvt, stopEvt;

  assign startEvt = evt.startEvt;
  assign stopEvt  = evt.stopEvt;

  i2c_strap_dp #(
    .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W),
    .STRAP_W(STRAP_W), .ADDR_HIGH(ADDR_HIGH)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrStrap(addrStrap), .cmd(cmd), .txData(txData), .evt(evt),
    .sclQ(sclQ), .sdaQ(sdaQ), .cntLast(cntLast), .cntFull(cntFull),
    .addrHit(addrHit), .rwBit(rwBit), .nextOut(nextOut), .loadMsb(loadMsb),
    .rxData(rxData), .rxValid(rxValid), .txLoad(txLoad)
  );

  i2c_strap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sdaQ(sdaQ),
    .cntLast(cntLast), .cntFull(cntFull), .addrHit(addrHit),
    .rwBit(rwBit), .nextOut(nextOut), .loadMsb(loadMsb),
    .cmd(cmd), .sdaDriveLow(sdaDriveLow)
  );
endmodule

// File: rtl/i2c_strap_chk.sv
`timescale 1ns/1ps
module i2c_strap_chk (
  input logic clk,
  input logic rst_n,
  input logic sclQ,
  input logic startEvt,
  input logic stopEvt,
  input logic sdaDriveLow,
  input logic rxValid,
  input logic txLoad
);
  p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdaDriveLow) |-> !sclQ);

  p_rx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);

  p_rx_not_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |-> !sdaDriveLow);

  p_tx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txLoad |=> !txLoad);

  p_stop_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stopEvt |=> !sdaDriveLow);

  p_start_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    startEvt |-> !sdaDriveLow);
endmodule

bind i2c_strap_slave i2c_strap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclQ(sclQ), .startEvt(startEvt),
  .stopEvt(stopEvt), .sdaDriveLow(sdaDriveLow), .rxValid(rxValid),
  .txLoad(txLoad)
);

// File: tb/i2c_strap_slave_tb.sv
`timescale 1ns/1ps
module i2c_strap_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclLine = 1'b1;
  logic sdaMst = 1'b1;
  logic [1:0] strap = 2'b00;
  wire  [7:0] txData;
  wire  sdaDriveLow, rxValid, txLoad;
  wire  [7:0] rxData;
  wire  sdaBus = sdaMst & ~sdaDriveLow;

  int tests = 0, fails = 0, qtr = 32;
  bit done = 1'b0;
  logic [7:0] rxLog [64];
  logic [7:0] txBuf [64];
  int rxCnt = 0, txIdx = 0, drvViol = 0;
  logic prevDrv = 1'b0;

  assign txData = txBuf[txIdx % 64];

  always #10 clk = ~clk;

  i2c_strap_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclIn(sclLine), .sdaIn(sdaBus),
    .addrStrap(strap), .txData(txData), .sdaDriveLow(sdaDriveLow),
    .rxData(rxData), .rxValid(rxValid), .txLoad(txLoad)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      rxLog[rxCnt % 64] <= rxData;
      rxCnt <= rxCnt + 1;
    end
    if (txLoad) txIdx <= txIdx + 1;
    if (rst_n && sdaDriveLow !== prevDrv && sclLine) drvViol = drvViol + 1;
    prevDrv <= sdaDriveLow;
  end

  function automatic logic [7:0] addrByte(input logic [1:0] s, input bit rd);
    return {5'b00111, s, rd};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (qtr) @(negedge clk);
  endtask

  task automatic busStart();
    sdaMst = 1'b1; waitq();
    sclLine = 1'b1; waitq();
    sdaMst = 1'b0; waitq();
    sclLine = 1'b0; waitq();
  endtask

  task automatic busStop();
    sdaMst = 1'b0; waitq();
    sclLine = 1'b1; waitq();
    sdaMst = 1'b1; waitq();
  endtask

  task automatic bitIo(input bit b, output bit s);
    sdaMst = b; waitq();
    sclLine = 1'b1; waitq();
    s = sdaBus; waitq();
    sclLine = 1'b0; waitq();
  endtask

  task automatic writeByte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bitIo(b[i], s);
    bitIo(1'b1, s);
    ack = !s;
  endtask

  task automatic readByte(output logic [7:0] b, input bit giveAck);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bitIo(1'b1, s);
      b[i] = s;
    end
    bitIo(!giveAck, s);
  endtask

  task automatic doWrite(input int n, input string tag);
    int base;
    bit ack;
    logic [7:0] sent [4];
    base = rxCnt;
    busStart();
    writeByte(addrByte(strap, 1'b0), ack);
    chk({tag, " R2 write addr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      sent[k] = 8'($urandom);
      writeByte(sent[k], ack);
      chk({tag, " R4 data ack"}, ack, 1);
    end
    busStop();
    chk({tag, " R4 rx count"}, rxCnt - base, n);
    for (int k = 0; k < n; k++)
      chk({tag, " R4 rx byte"}, rxLog[(base + k) % 64], sent[k]);
  endtask

  task automatic doRead(input int n, input bit stopAfter, input string tag);
    int base;
    bit ack;
    logic [7:0] b;
    base = txIdx;
    for (int k = 0; k < n; k++) txBuf[(base + k) % 64] = 8'($urandom);
    busStart();
    writeByte(addrByte(strap, 1'b1), ack);
    chk({tag, " R2 read addr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      readByte(b, k != n - 1);
      chk({tag, " R5 read byte"}, b, txBuf[(base + k) % 64]);
    end
    chk({tag, " R6 load count"}, txIdx - base, n);
    if (stopAfter) busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", tests, -1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    int base;
    void'($urandom(32'd51973));
    for (int i = 0; i < 64; i++) txBuf[i] = 8'h00;

    // R1: reset state
    repeat (5) @(negedge clk);
    chk("R1 drive in reset", sdaDriveLow, 0);
    chk("R1 rxValid in reset", rxValid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 drive after reset", sdaDriveLow, 0);
    chk("R1 txLoad after reset", txLoad, 0);

    // R2/R3: strap sweep
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      for (int a = 0; a < 4; a++) begin
        busStart();
        writeByte(addrByte(2'(a), 1'b0), ack);
        busStop();
        chk((a == s) ? "R2 match ack" : "R3 mismatch no ack", ack, (a == s) ? 1 : 0);
      end
    end
    busStart();
    writeByte(8'hA0, ack);
    busStop();
    chk("R3 foreign prefix no ack", ack, 0);

    // R3: data after mismatch ignored, then normal write
    strap = 2'b10;
    base = rxCnt;
    busStart();
    writeByte(addrByte(2'b01, 1'b0), ack);
    chk("R3 wrong addr no ack", ack, 0);
    writeByte(8'h5A, ack);
    chk("R3 data after mismatch no ack", ack, 0);
    busStop();
    chk("R3 no rx after mismatch", rxCnt - base, 0);
    doWrite(2, "R3 recover");

    // R7: repeated START in the middle of a write
    base = rxCnt;
    busStart();
    writeByte(addrByte(strap, 1'b0), ack);
    chk("R7 first addr ack", ack, 1);
    writeByte(8'hA5, ack);
    chk("R7 first data ack", ack, 1);
    busStart();
    writeByte(addrByte(strap, 1'b0), ack);
    chk("R7 addr after rep start no ack", ack, 0);
    writeByte(8'h3C, ack);
    chk("R7 data after rep start no ack", ack, 0);
    busStop();
    chk("R7 rx count", rxCnt - base, 1);
    chk("R7 rx byte", rxLog[base % 64], 8'hA5);
    doWrite(1, "R7 recover");

    // R5/R6: read with NACK, then extra clocks stay released
    strap = 2'b01;
    doRead(2, 1'b0, "R6 nack");
    base = txIdx;
    readByte(b, 1'b0);
    chk("R6 released after nack", b, 8'hFF);
    chk("R6 no load after nack", txIdx - base, 0);
    busStop();
    doRead(3, 1'b1, "R5 read3");

    // R9: standard rate
    qtr = 125;
    strap = 2'b11;
    doWrite(2, "R9 std write");
    doRead(2, 1'b1, "R9 std read");
    qtr = 32;

    // Random mix at fast rate
    for (int t = 0; t < 6; t++) begin
      strap = 2'($urandom);
      if ($urandom % 2) doRead(1 + int'($urandom % 3), 1'b1, "R5 rand read");
      else doWrite(1 + int'($urandom % 3), "R4 rand write");
    end

    chk("R8 drive changes while scl high", drvViol, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule